// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block holds the digital side of an on-chip successive-approximation analog-to-digital converter. Software reaches it through a small register port: a control/status register, a read-only result register and a clock-configuration register. Any write to the control register starts a conversion. The block makes a conversion clock by dividing either the bus clock or an alternate tick input by a power of two. It then walks an 8-bit trial code from MSB to LSB against an external comparator and loads the final code into the result register.

A conversion is either single or continuous. Its end is reported by a status flag that software polls or, when enabled, by an interrupt request. Writing the all-ones code into the channel field turns the converter off. The comparator, the trial DAC and the analog multiplexer sit outside the block. They are driven by `dac_code`, `ch_sel` and `adc_on`, and the comparison result comes back on `cmp_hi`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Register map. Address 0 is control/status: bit 7 is the read-only done flag, bit 6 is interrupt enable, bit 5 is continuous mode and bits 4:0 are the channel. Address 1 is the result. Address 2 is clock configuration: bits 2:0 are the divide exponent and bit 3 is the source select. After reset, every register reads 0, `irq` is 0, `dac_code` is 0 and `adc_on` is 1.
- R2: With divide exponent 0 on the bus clock, the interrupt request becomes visible exactly 17 clock cycles after the edge that takes the control write. In general, a conversion ends 16 conversion-clock ticks after the first tick that follows the write.
- R3: The search decides one bit per tick, from MSB to LSB, by presenting `dac_code` with the trial bit set. The bit is kept when `cmp_hi` is 1. The result therefore equals the largest code that the comparator accepts, including the end codes 0x00 and 0xFF.
- R4: With interrupts disabled, the done flag (status bit 7) is set at the end of a conversion. It is cleared by a read of the result register or by a control write.
- R5: With interrupts enabled, `irq` is raised at the end of a conversion and the done flag stays 0.
- R6: `irq` is cleared by a read of the result register or by a control write.
- R7: In single mode, exactly one conversion runs per control write.
- R8: In continuous mode, conversions follow each other every 16 ticks until software writes the control register again. Each one overwrites the result, whether or not it was read.
- R9: A control write during a conversion discards it and starts a new one, timed from that write.
- R10: Channel code 0x1F drives `adc_on` low and starts no conversion. `irq` stays 0 and the result keeps its value. `ch_sel` always shows the channel field.
- R11: The conversion clock is the selected source divided by 2 to the power of the divide exponent. With exponent 2, a conversion ends 65 to 68 bus cycles after the write edge.
- R12: With source select 1, ticks come from `alt_tick` pulses instead of every bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags on a result read) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| alt_tick | input | 1 | Alternate clock-source enable pulse |
| cmp_hi | input | 1 | Comparator: analog input is at or above the DAC level |
| dac_code | output | 8 | Trial code for the DAC |
| ch_sel | output | 5 | Selected analog channel |
| adc_on | output | 1 | Converter power enable |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit result, a 5-bit channel field, a 3-bit divide exponent and 16 ticks per conversion. At run time it programs divide exponents 0 and 2 and the alternate source. Exponent 0 makes the latency an exact 17-cycle value. Exponent 2 and a one-in-three alternate tick expose the one-tick spread that comes from synchronising the start, which the bench checks as a window. The 5-bit channel field makes the all-ones power-down code reachable. The 16-tick frame allows back-to-back continuous conversions to be timed exactly.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W      = 8,
  parameter int CH_W       = 5,
  parameter int DIV_W      = 3,
  parameter int CONV_TICKS = 16,
  parameter int REG_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             alt_tick,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  ch_sel,
  output logic             adc_on,
  output logic             irq
);
  localparam int PRE_W     = (1 << DIV_W) - 1;
  localparam int CNT_W     = $clog2(CONV_TICKS);
  localparam int FIRST_BIT = CONV_TICKS - RES_W;
  localparam int LAST      = CONV_TICKS - 1;
  localparam int CONT_BIT  = CH_W;
  localparam int IEN_BIT   = CH_W + 1;
  localparam logic [CH_W-1:0] CH_OFF = '1;

  logic             ien_q, cont_q, coco_q, irq_q, src_q, pend_q, busy_q;
  logic [CH_W-1:0]  ch_q;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_cnt, pre_mask;
  logic [CNT_W-1:0] cnt_q, bit_idx;
  logic [RES_W-1:0] sar_q, sar_next, result_q, trial;
  logic             src_tick, cclk, ctrl_wr, clk_wr, res_rd, in_bits, done_w;
  logic             unused_bits;

  assign ctrl_wr  = reg_wr && reg_addr == 2'd0;
  assign clk_wr   = reg_wr && reg_addr == 2'd2;
  assign res_rd   = reg_rd && reg_addr == 2'd1;

  assign src_tick = src_q ? alt_tick : 1'b1;
  assign pre_mask = ~({PRE_W{1'b1}} << div_q);
  assign cclk     = src_tick && pre_cnt == pre_mask;

  assign in_bits  = busy_q && cnt_q >= CNT_W'(FIRST_BIT);
  assign bit_idx  = CNT_W'(LAST) - cnt_q;
  assign trial    = in_bits ? (RES_W'(1) << bit_idx) : '0;
  assign dac_code = sar_q | trial;
  assign sar_next = cmp_hi ? dac_code : sar_q;
  assign done_w   = cclk && busy_q && !pend_q && cnt_q == CNT_W'(LAST) && !ctrl_wr;

  assign ch_sel      = ch_q;
  assign adc_on      = ch_q != CH_OFF;
  assign irq         = irq_q;
  assign unused_bits = ^reg_wdata[REG_W-1:IEN_BIT+1];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = REG_W'({coco_q, ien_q, cont_q, ch_q});
      2'd1:    reg_rdata = REG_W'(result_q);
      2'd2:    reg_rdata = REG_W'({src_q, div_q});
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      src_q   <= 1'b0;
      pre_cnt <= '0;
    end else if (clk_wr) begin
      div_q   <= reg_wdata[DIV_W-1:0];
      src_q   <= reg_wdata[DIV_W];
      pre_cnt <= '0;
    end else if (src_tick) begin
      pre_cnt <= cclk ? '0 : pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= 1'b0;
      cont_q   <= 1'b0;
      ch_q     <= '0;
      coco_q   <= 1'b0;
      irq_q    <= 1'b0;
      pend_q   <= 1'b0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      sar_q    <= '0;
      result_q <= '0;
    end else if (ctrl_wr) begin
      ien_q  <= reg_wdata[IEN_BIT];
      cont_q <= reg_wdata[CONT_BIT];
      ch_q   <= reg_wdata[CH_W-1:0];
      coco_q <= 1'b0;
      irq_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sar_q  <= '0;
      pend_q <= reg_wdata[CH_W-1:0] != CH_OFF;
    end else begin
      if (res_rd) begin
        coco_q <= 1'b0;
        irq_q  <= 1'b0;
      end
      if (cclk) begin
        if (pend_q) begin
          pend_q <= 1'b0;
          busy_q <= 1'b1;
          cnt_q  <= '0;
          sar_q  <= '0;
        end else if (busy_q) begin
          if (in_bits) sar_q <= sar_next;
          if (cnt_q == CNT_W'(LAST)) begin
            result_q <= sar_next;
            if (ien_q) irq_q  <= 1'b1;
            else       coco_q <= 1'b1;
            cnt_q <= '0;
            if (cont_q) sar_q <= '0;
            else        busy_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W = 8,
  parameter int CH_W  = 5,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             irq,
  input logic             coco,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result
);
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && coco)); // R5

  AST_DONE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (irq || coco)); // R4

  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (!irq && !coco)); // R6

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1 && !done) |=> (!irq && !coco)); // R6

  AST_PWR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[CH_W-1:0] == '1) |=> !busy); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result)); // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W), .CH_W(CH_W), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .coco(coco_q),
  .busy(busy_q), .done(done_w), .result(result_q)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, alt_tick = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, dac_code, ain = '0;
  logic [4:0] ch_sel;
  logic       adc_on, irq, cmp_hi;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit mon_en = 0, mon_busy = 0, done_flag = 0;

  always #5 clk = ~clk;
  assign cmp_hi = ain >= dac_code;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alt_tick(alt_tick), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .ch_sel(ch_sel), .adc_on(adc_on), .irq(irq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_rng(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!irq && n < 400) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic wait_sb();
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // alternate source: one pulse every third cycle
  initial begin
    int ac = 0;
    forever begin
      @(negedge clk);
      alt_tick = (ac == 2);
      ac = (ac + 1) % 3;
    end
  end

  // monitor: scoreboard pop on each interrupt
  initial begin
    int v, e;
    forever begin
      @(negedge clk);
      if (mon_en && irq) begin
        mon_busy = 1;
        bus_rd(2'd1, v);
        if (exp_q.size() == 0) begin
          check("R7 unexpected conversion", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check("R3 result", v, e);
        end
        check("R6 irq cleared by result read", irq, 0);
        mon_busy = 0;
      end
    end
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, n;
    int codes[5] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h7F};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 irq", irq, 0);
    check("R1 dac_code", dac_code, 0);
    check("R1 adc_on", adc_on, 1);
    bus_rd(2'd0, v); check("R1 status", v, 0);
    bus_rd(2'd1, v); check("R1 result", v, 0);
    bus_rd(2'd2, v); check("R1 clkcfg", v, 0);

    mon_en = 1;
    ain = 8'hA5; exp_q.push_back(8'hA5);
    bus_wr(2'd0, 8'h43);
    check("R10 ch_sel", ch_sel, 3);
    measure(n); check("R2 latency", n, 17);
    wait_sb();

    foreach (codes[i]) begin
      ain = codes[i][7:0]; exp_q.push_back(codes[i]);
      bus_wr(2'd0, 8'h40);
      measure(n); check("R2 latency", n, 17);
      wait_sb();
    end
    repeat (40) @(negedge clk);
    check("R7 no second conversion", irq, 0);

    mon_en = 0;
    ain = 8'h5C;
    bus_wr(2'd0, 8'h02);
    repeat (20) @(negedge clk);
    check("R5 irq off when disabled", irq, 0);
    bus_rd(2'd0, v); check("R4 done flag set", v[7], 1);
    bus_rd(2'd1, v); check("R3 polled result", v, 8'h5C);
    bus_rd(2'd0, v); check("R4 done cleared by read", v[7], 0);
    bus_wr(2'd0, 8'h02);
    repeat (20) @(negedge clk);
    bus_rd(2'd0, v); check("R4 done set again", v[7], 1);
    bus_wr(2'd0, 8'h02);
    bus_rd(2'd0, v); check("R4 done cleared by write", v[7], 0);
    repeat (20) @(negedge clk);
    bus_rd(2'd1, v);

    bus_wr(2'd0, 8'h40);
    repeat (20) @(negedge clk);
    check("R5 irq raised", irq, 1);
    bus_rd(2'd0, v); check("R5 done flag stays 0", v[7], 0);
    bus_wr(2'd0, 8'h40);
    check("R6 irq cleared by write", irq, 0);
    measure(n); check("R2 latency", n, 17);
    bus_rd(2'd1, v);

    mon_en = 1;
    ain = 8'h10;
    bus_wr(2'd0, 8'h40);
    repeat (10) @(negedge clk);
    ain = 8'h2B; exp_q.push_back(8'h2B);
    bus_wr(2'd0, 8'h40);
    measure(n); check("R9 restart latency", n, 17);
    wait_sb();

    mon_en = 0;
    ain = 8'h33;
    bus_wr(2'd0, 8'h60);
    measure(n); check("R8 first continuous", n, 17);
    ain = 8'h44;
    repeat (16) @(posedge clk);
    @(negedge clk);
    bus_rd(2'd1, v); check("R8 overwritten result", v, 8'h44);
    measure(n); check("R8 next conversion period", n, 15);
    bus_wr(2'd0, 8'h40);
    measure(n); check("R8 stop via single write", n, 17);
    bus_rd(2'd1, v);
    repeat (40) @(negedge clk);
    check("R7 continuous stopped", irq, 0);

    ain = 8'h99;
    bus_wr(2'd0, 8'h5F);
    check("R10 adc_on low", adc_on, 0);
    check("R10 ch_sel", ch_sel, 5'h1F);
    repeat (40) @(negedge clk);
    check("R10 no irq", irq, 0);
    bus_rd(2'd1, v); check("R10 result kept", v, 8'h44);

    mon_en = 1;
    bus_wr(2'd2, 8'h02);
    bus_rd(2'd2, v); check("R11 clkcfg readback", v, 8'h02);
    for (int k = 0; k < 3; k++) begin
      ain = 8'h9E - 8'(k); exp_q.push_back(8'h9E - k);
      repeat (k) @(negedge clk);
      bus_wr(2'd0, 8'h40);
      measure(n); check_rng("R11 divided latency", n, 65, 68);
      wait_sb();
    end

    bus_wr(2'd2, 8'h08);
    for (int k = 0; k < 2; k++) begin
      ain = 8'h61 + 8'(k); exp_q.push_back(8'h61 + k);
      repeat (k) @(negedge clk);
      bus_wr(2'd0, 8'h40);
      measure(n); check_rng("R12 alternate source latency", n, 49, 51);
      wait_sb();
    end
    bus_wr(2'd2, 8'h00);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule